// File: doc/BRIEF.md
# Eight-Character Display Line Register

A small memory-mapped register window that holds one line of eight ASCII characters for a character display. A bus master reads or writes 1, 2, 4 or 8 bytes at any byte offset inside an 8-byte window. Byte lanes are placed little-endian: bus lane k lands in character (offset + k) mod 8, so an access running past the last character wraps back to character 0.

The whole line is presented in parallel on `line_o`, character j in bits [8j+7:8j]. Every accepted write raises a one-cycle `refresh_o` strobe that tells a downstream display driver to redraw the full line from the first column. A one-time initialisation event, `open_evt`, fills the line with spaces and also raises the strobe. A flag blocks any later repeat of that fill.

Top module: `charline_regs`

## Requirements
- R1: While and after reset (`rst_n` low), `line_o` is all zero, `refresh_o` is low, and the blank-fill flag is clear, so a later `open_evt` is still honoured.
- R2: A write of length N (`acc_bytes` holds the byte count N, valid for 1, 2, 4 or 8) with `wr_en` high stores bus byte k (`wdata[8k+7:8k]`) into character (`addr` + k) mod 8 for k = 0..N-1. The new value appears on `line_o` after the next rising clock edge.
- R3: An access whose bytes run past character 7 wraps and continues at character 0.
- R4: A valid write leaves every character it does not touch unchanged.
- R5: A read of valid length N with `rd_en` high returns character (`addr` + k) mod 8 in `rdata[8k+7:8k]` for k < N. All higher bytes of `rdata` are zero. The result is combinational in the same cycle.
- R6: `rdata` is zero whenever `rd_en` is low.
- R7: For any `acc_bytes` other than 1, 2, 4 or 8, a write changes no character and raises no strobe, and a read returns zero.
- R8: `refresh_o` is high for exactly the one cycle after the edge that accepted a valid write. `line_o` already shows the written data in that cycle.
- R9: The first `open_evt` after reset loads 0x20 into all eight characters and pulses `refresh_o` one cycle later. Every later `open_evt` changes nothing and raises no strobe.
- R10: When the first `open_evt` and a valid write arrive in the same cycle, the line is first filled with spaces and the written bytes then overlay it. A single strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | 3 | Byte offset of lane 0 within the window |
| acc_bytes | input | 4 | Access length in bytes (1, 2, 4, 8 valid) |
| wdata | input | 64 | Write data, lane 0 in the low byte |
| rdata | output | 64 | Read data, lane 0 in the low byte |
| open_evt | input | 1 | One-time initialisation event |
| line_o | output | 64 | Full line, character j in bits [8j+7:8j] |
| refresh_o | output | 1 | One-cycle redraw strobe |

## Verification
A wrong lane rotation or wrap shows on `line_o` one edge after the write, and on `rdata` in the same cycle as the read. The bench therefore compares both after every access of every length at every offset. A faulty length decode either corrupts neighbouring characters or produces a spurious or missing `refresh_o` on the following cycle. A blank-fill flag that is stuck or never set shows up as a second space fill, or a missing one, right after the next `open_evt`.

// File: rtl/charline_pkg.sv
package charline_pkg;

  // Access length is valid when it is a nonzero power of two no larger than the line.
  function automatic logic len_ok(input int unsigned n, input int unsigned max_n);
    return (n != 0) && ((n & (n - 1)) == 0) && (n <= max_n);
  endfunction

endpackage

// File: rtl/charline_lane_map.sv
module charline_lane_map
  import charline_pkg::*;
#(
  parameter int NUM_CHARS = 8,
  parameter int CHAR_W    = 8,
  localparam int IDX_W    = $clog2(NUM_CHARS),
  localparam int LEN_W    = IDX_W + 1,
  localparam int BUS_W    = NUM_CHARS * CHAR_W
) (
  input  logic             wr_go,
  input  logic [IDX_W-1:0] addr,
  input  logic [LEN_W-1:0] nbytes,
  input  logic [BUS_W-1:0] wdata,
  output logic [NUM_CHARS-1:0] char_we,
  output logic [BUS_W-1:0] char_wd
);

  for (genvar j = 0; j < NUM_CHARS; j++) begin : g_char
    logic [IDX_W-1:0] lane;
    assign lane = IDX_W'(j) - addr;  // modulo wrap by width
    assign char_we[j] = wr_go && ({1'b0, lane} < nbytes);
    assign char_wd[j*CHAR_W +: CHAR_W] = wdata[lane*CHAR_W +: CHAR_W];
  end

endmodule

// File: rtl/charline_rd_mux.sv
module charline_rd_mux
  import charline_pkg::*;
#(
  parameter int NUM_CHARS = 8,
  parameter int CHAR_W    = 8,
  localparam int IDX_W    = $clog2(NUM_CHARS),
  localparam int LEN_W    = IDX_W + 1,
  localparam int BUS_W    = NUM_CHARS * CHAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_go,
  input  logic [IDX_W-1:0] addr,
  input  logic [LEN_W-1:0] nbytes,
  input  logic [BUS_W-1:0] line,
  output logic [BUS_W-1:0] rdata
);

  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_lane
    logic [IDX_W-1:0] src;
    logic             used;
    assign src  = addr + IDX_W'(k);
    assign used = rd_go && (LEN_W'(k) < nbytes);
    assign rdata[k*CHAR_W +: CHAR_W] = used ? line[src*CHAR_W +: CHAR_W] : '0;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |-> (rdata == '0));  // R6

  AST_RD_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> (rdata[CHAR_W-1:0] == line[addr*CHAR_W +: CHAR_W]));  // R5

endmodule

// File: rtl/charline_store.sv
module charline_store #(
  parameter int          NUM_CHARS = 8,
  parameter int          CHAR_W    = 8,
  parameter logic [7:0]  BLANK     = 8'h20,
  localparam int         BUS_W     = NUM_CHARS * CHAR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 open_evt,
  input  logic [NUM_CHARS-1:0] char_we,
  input  logic [BUS_W-1:0]     char_wd,
  output logic [BUS_W-1:0]     line,
  output logic                 refresh
);

  logic [BUS_W-1:0] line_q, line_d;
  logic             blank_done_q, blank_done_d;
  logic             refresh_q;
  logic             blank_go;
  logic             upd_en;

  assign blank_go = open_evt && !blank_done_q;
  assign upd_en   = blank_go || (|char_we);

  always_comb begin
    line_d       = line_q;
    blank_done_d = blank_done_q | blank_go;
    if (blank_go) begin
      for (int j = 0; j < NUM_CHARS; j++) line_d[j*CHAR_W +: CHAR_W] = CHAR_W'(BLANK);
    end
    for (int j = 0; j < NUM_CHARS; j++) begin
      if (char_we[j]) line_d[j*CHAR_W +: CHAR_W] = char_wd[j*CHAR_W +: CHAR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q       <= '0;
      blank_done_q <= 1'b0;
      refresh_q    <= 1'b0;
    end else begin
      if (upd_en) line_q <= line_d;
      if (blank_go) blank_done_q <= blank_done_d;
      refresh_q <= upd_en;
    end
  end

  assign line    = line_q;
  assign refresh = refresh_q;

  AST_BLANK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    blank_done_q |=> blank_done_q);  // R9

  AST_IDLE_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (char_we == '0 && !blank_go) |=> $stable(line_q));  // R4

endmodule

// File: rtl/charline_regs.sv
module charline_regs
  import charline_pkg::*;
#(
  parameter int         NUM_CHARS = 8,
  parameter int         CHAR_W    = 8,
  parameter logic [7:0] BLANK     = 8'h20,
  localparam int        IDX_W     = $clog2(NUM_CHARS),
  localparam int        LEN_W     = IDX_W + 1,
  localparam int        BUS_W     = NUM_CHARS * CHAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] addr,
  input  logic [LEN_W-1:0] acc_bytes,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic             open_evt,
  output logic [BUS_W-1:0] line_o,
  output logic             refresh_o
);

  logic                 len_valid;
  logic [NUM_CHARS-1:0] char_we;
  logic [BUS_W-1:0]     char_wd;

  assign len_valid = len_ok(int'(acc_bytes), NUM_CHARS);

  charline_lane_map #(.NUM_CHARS(NUM_CHARS), .CHAR_W(CHAR_W)) i_lane_map (
    .wr_go   (wr_en && len_valid),
    .addr    (addr),
    .nbytes  (acc_bytes),
    .wdata   (wdata),
    .char_we (char_we),
    .char_wd (char_wd)
  );

  charline_store #(.NUM_CHARS(NUM_CHARS), .CHAR_W(CHAR_W), .BLANK(BLANK)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_evt (open_evt),
    .char_we  (char_we),
    .char_wd  (char_wd),
    .line     (line_o),
    .refresh  (refresh_o)
  );

  charline_rd_mux #(.NUM_CHARS(NUM_CHARS), .CHAR_W(CHAR_W)) i_rd_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_go  (rd_en && len_valid),
    .addr   (addr),
    .nbytes (acc_bytes),
    .line   (line_o),
    .rdata  (rdata)
  );

  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && len_valid) |=> refresh_o);  // R8

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !open_evt) |=> !refresh_o);  // R8

  AST_BAD_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!len_valid && !open_evt) |=> (!refresh_o && $stable(line_o)));  // R7

  AST_BAD_LEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !len_valid |-> (rdata == '0));  // R7

  AST_WRITE_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && len_valid) |=> (line_o[$past(addr)*CHAR_W +: CHAR_W] == $past(wdata[CHAR_W-1:0])));  // R2

endmodule

// File: tb/test_charline_regs.sv
module test_charline_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, open_evt;
  logic [2:0]  addr;
  logic [3:0]  acc_bytes;
  logic [63:0] wdata, rdata, line_o;
  logic        refresh_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [8];

  always #5 clk = ~clk;

  charline_regs i_charline_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .acc_bytes(acc_bytes), .wdata(wdata), .rdata(rdata), .open_evt(open_evt),
    .line_o(line_o), .refresh_o(refresh_o)
  );

  function automatic logic [63:0] mdl_line();
    logic [63:0] v;
    for (int j = 0; j < 8; j++) v[j*8 +: 8] = mdl[j];
    return v;
  endfunction

  function automatic logic valid_len(input int n);
    return n == 1 || n == 2 || n == 4 || n == 8;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input int n, input logic [63:0] d, input logic op, input string req);
    logic fires;
    fires = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); acc_bytes = 4'(n); wdata = d; open_evt = op;
    @(posedge clk); #1;
    if (op && !fires) begin end
    wr_en = 1'b0; open_evt = 1'b0;
  endtask

  // Applies model update for a write; returns whether a strobe is expected.
  function automatic logic mdl_write(input int a, input int n, input logic [63:0] d);
    if (!valid_len(n)) return 1'b0;
    for (int k = 0; k < n; k++) mdl[(a + k) % 8] = d[k*8 +: 8];
    return 1'b1;
  endfunction

  task automatic write_chk(input int a, input int n, input logic [63:0] d, input string req);
    logic exp_rf;
    exp_rf = mdl_write(a, n, d);
    do_write(a, n, d, 1'b0, req);
    check({req, " line"}, line_o, mdl_line());
    check("R8 strobe", {63'd0, refresh_o}, {63'd0, exp_rf});
    @(posedge clk); #1;
    check("R8 strobe width", {63'd0, refresh_o}, 64'd0);
  endtask

  task automatic read_chk(input int a, input int n, input string req);
    logic [63:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = 3'(a); acc_bytes = 4'(n);
    #1;
    e = '0;
    if (valid_len(n)) for (int k = 0; k < n; k++) e[k*8 +: 8] = mdl[(a + k) % 8];
    check(req, rdata, e);
    rd_en = 1'b0;
    #1;
    check("R6 idle read", rdata, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; open_evt = 1'b0;
    addr = '0; acc_bytes = '0; wdata = '0;
    for (int j = 0; j < 8; j++) mdl[j] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset line", line_o, 64'd0);
    check("R1 reset strobe", {63'd0, refresh_o}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R9 + R10: first open event together with a 2-byte write at offset 7 (wraps)
    for (int j = 0; j < 8; j++) mdl[j] = 8'h20;
    void'(mdl_write(7, 2, 64'h0000_0000_0000_4241));
    do_write(7, 2, 64'h0000_0000_0000_4241, 1'b1, "R10");
    check("R10 blank+overlay", line_o, mdl_line());
    check("R9 blank strobe", {63'd0, refresh_o}, 64'd1);
    @(posedge clk); #1;
    // R9: second open event ignored
    @(negedge clk); open_evt = 1'b1;
    @(posedge clk); #1; open_evt = 1'b0;
    check("R9 repeat open line", line_o, mdl_line());
    check("R9 repeat open strobe", {63'd0, refresh_o}, 64'd0);

    // R2/R3/R4/R5: sweep every offset and valid length
    for (int n = 1; n <= 8; n = n * 2) begin
      for (int a = 0; a < 8; a++) begin
        logic [63:0] d;
        d = {8{8'(a * 16 + n)}} ^ 64'h0706_0504_0302_0100;
        write_chk(a, n, d, (a + n > 8) ? "R3 wrap write" : "R2 write");
        for (int ra = 0; ra < 8; ra++) read_chk(ra, n, "R5 read");
      end
    end

    // R4: single byte write leaves others intact
    write_chk(5, 1, 64'hFFFF_FFFF_FFFF_FF7E, "R4 untouched");

    // R7: invalid lengths
    for (int n = 0; n < 16; n++) begin
      if (!valid_len(n)) begin
        write_chk(n % 8, n, 64'hDEAD_BEEF_CAFE_F00D, "R7 bad-length write");
        read_chk(n % 8, n, "R7 bad-length read");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule